// File: doc/BRIEF.md
# Signed-Count Shift and Arithmetic Execution Unit

This block is the integer execution stage of a small load/store RISC core. It takes a 32-bit first operand and a second operand. The second operand is either a register value or a 16-bit immediate widened with its sign. The block returns a 32-bit result and an overflow flag. It performs addition, subtraction, a compare that always keeps the sign of the difference, and two shifts.

Each shift reads its distance as one signed number. A positive distance moves bits toward the MSB and a negative distance moves them toward the LSB. Subtraction reports signed overflow. Compare never does. When the true difference does not fit, compare gives a value whose magnitude is wrong but whose sign bit is still correct, so a following branch on sign stays valid.

The arithmetic is combinational. A parameter `OUT_REG` (default 1) adds an output register for timing.

Top module: `xalu_exec`

## Requirements
- R1: When `use_imm` is 1, operand B is `imm` sign-extended to 32 bits, with bit 15 copied into bits 31..16. When `use_imm` is 0, operand B is `opb_reg`.
- R2: With `op_sel`=0 (add), `result` is A+B modulo 2^32. `ovf` is 1 exactly when the true signed sum lies outside -2^31..2^31-1.
- R3: With `op_sel`=1 (subtract), `result` is A-B modulo 2^32. `ovf` is 1 exactly when the true signed difference lies outside -2^31..2^31-1.
- R4: With `op_sel`=2 (compare), `ovf` is 0. If the true difference A-B is in range, `result` equals A-B. If it is out of range, `result` bit 31 is the sign of the true difference and bits 30..0 are the low 31 bits of A-B.
- R5: With `op_sel`=3 (logical shift) or 4 (arithmetic shift), and B read as a signed count from 0 to 31, `result` is A shifted toward the MSB by that count, with zeros filled in.
- R6: With a signed count from -1 to -31, `result` is A shifted toward the LSB by the count's magnitude. The logical shift fills with zeros and the arithmetic shift fills with copies of A bit 31.
- R7: A count of 32 or more, or of -32 or less, saturates. Left shifts and logical right shifts give 0. An arithmetic right shift gives 32 copies of A bit 31.
- R8: `ovf` is 0 for the shift and compare codes. The codes 5, 6 and 7 give `result` 0 and `ovf` 0.
- R9: With `OUT_REG`=1, `result` and `ovf` change one `clk` rising edge after the inputs. A rising edge with `rst_n` low sets both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 cmp, 3 logical shift, 4 arithmetic shift |
| use_imm | input | 1 | Selects the immediate as operand B |
| opa | input | 32 | Operand A |
| opb_reg | input | 32 | Register value for operand B |
| imm | input | 16 | Immediate field for operand B |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow flag for add and subtract |

## Verification
The embedded properties assume that `op_sel`, the operands and `use_imm` are stable when they are sampled at each rising edge. The bench therefore drives every input on the falling edge only. The properties also assume that the code is one of the eight values of the 3-bit field, so every code the bench applies, including 5 to 7, stays inside the defined behaviour.

The stimulus covers three areas:
- every shift distance from -40 to 40, supplied both from a register and from the immediate path;
- a cross product of the signed boundary values for add, subtract and compare;
- random operand pairs.

Every code and operand source used stays inside what the properties assume.

// File: rtl/xalu_pkg.sv
// Package: shared operation encoding for the execution unit.
// Assumes a 3-bit operation field; codes 5..7 are undefined operations.
package xalu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_LSH = 3'd3,
        OP_ASH = 3'd4
    } xalu_op_e;
endpackage

// File: rtl/xalu_opb_sel.sv
// Operand-B source selector: picks the register value or the
// sign-extended immediate. Assumes IMM_W < XLEN.
module xalu_opb_sel #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic             use_imm,
    input  logic [XLEN-1:0]  reg_val,
    input  logic [IMM_W-1:0] imm_val,
    output logic [XLEN-1:0]  opb
);
    localparam int EXT_W = XLEN - IMM_W;

    // Choose the operand source, replicating the immediate sign bit upward.
    always_comb begin
        if (use_imm) begin
            opb = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        end else begin
            opb = reg_val;
        end
    end
endmodule

// File: rtl/xalu_addsub.sv
// Adder/subtractor with a sign-preserving compare mode.
// Works on an (XLEN+1)-bit sign-extended sum, so the true sign is always
// available. Assumes do_cmp implies do_sub. clk/rst_n only time the checks.
module xalu_addsub #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_sub,
    input  logic            do_cmp,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            ovf
);
    localparam int MSB = XLEN - 1;
    localparam int WW  = XLEN + 1;

    logic [WW-1:0] a_w;
    logic [WW-1:0] b_w;
    logic [WW-1:0] wide;
    logic          out_of_range;

    // Form the widened operands and the exact signed sum or difference.
    always_comb begin
        a_w  = {a[MSB], a};
        b_w  = {b[MSB], b};
        wide = do_sub ? (a_w - b_w) : (a_w + b_w);
    end

    // The true value fits in XLEN bits only if the two top bits agree.
    always_comb begin
        out_of_range = wide[XLEN] ^ wide[MSB];
    end

    // Pick the result and the flag; compare keeps the true sign and never flags.
    always_comb begin
        if (do_cmp && out_of_range) begin
            res = {wide[XLEN], wide[MSB-1:0]};
        end else begin
            res = wide[MSB:0];
        end
        ovf = out_of_range & ~do_cmp;
    end

    // R2: add overflow means equal input signs and a changed result sign
    p_add_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !do_sub |-> (ovf == ((a[MSB] == b[MSB]) && (res[MSB] != a[MSB]))));

    // R3: subtract overflow means differing input signs and a result sign unlike A
    p_sub_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_sub && !do_cmp) |-> (ovf == ((a[MSB] != b[MSB]) && (res[MSB] != a[MSB]))));

    // R4: the compare sign always matches the signed ordering of the inputs
    p_cmp_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_cmp |-> ((res[MSB] == ($signed(a) < $signed(b))) && !ovf));
endmodule

// File: rtl/xalu_shift.sv
// Shifter driven by one signed count: a non-negative count moves bits
// toward the MSB, a negative one toward the LSB. Any magnitude >= XLEN
// saturates. Assumes XLEN is a power of two. clk/rst_n only time the checks.
module xalu_shift #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arith,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] cnt,
    output logic [XLEN-1:0] res
);
    localparam int MSB = XLEN - 1;
    localparam int SHW = $clog2(XLEN);
    localparam int MW  = XLEN + 1;
    localparam logic [MW-1:0] LIMIT = MW'(XLEN);

    logic          neg;
    logic [MW-1:0] mag;
    logic          sat;
    logic [SHW-1:0] amt;
    logic [XLEN-1:0] fill;

    // Split the count into direction and a magnitude that cannot wrap.
    always_comb begin
        neg = cnt[MSB];
        mag = neg ? (MW'(0) - {1'b1, cnt}) : {1'b0, cnt};
        sat = (mag >= LIMIT);
        amt = mag[SHW-1:0];
    end

    // The saturated value: sign copies for arithmetic right shifts, zero otherwise.
    always_comb begin
        fill = (arith && neg) ? {XLEN{a[MSB]}} : '0;
    end

    // Apply the shift in the chosen direction, or the saturated value.
    always_comb begin
        if (sat) begin
            res = fill;
        end else if (!neg) begin
            res = a << amt;
        end else if (arith) begin
            res = $unsigned($signed(a) >>> amt);
        end else begin
            res = a >> amt;
        end
    end

    // R7: a saturated left or logical shift gives zero
    p_sat_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(cnt) >= XLEN || (!arith && $signed(cnt) <= -XLEN)) |-> (res == '0));

    // R6: an arithmetic right shift keeps the sign bit of A
    p_asr_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arith && $signed(cnt) < 0) |-> (res[MSB] == a[MSB]));

    // R5: a zero count passes A through unchanged
    p_zero_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (res == a));
endmodule

// File: rtl/xalu_exec.sv
// Top of the execution unit. Selects operand B, runs the arithmetic and
// shift datapaths in parallel, steers their results by op_sel, and can
// register the outputs. Assumes op_sel is one of the eight 3-bit codes;
// codes 5..7 give zero with no overflow.
module xalu_exec
    import xalu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_sel,
    input  logic             use_imm,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb_reg,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  result,
    output logic             ovf
);
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] as_res;
    logic            as_ovf;
    logic [XLEN-1:0] sh_res;
    logic            is_sub_like;
    logic            is_cmp;
    logic            is_ash;
    logic [XLEN-1:0] res_next;
    logic            ovf_next;

    // Decode the control lines that the datapaths use.
    always_comb begin
        is_sub_like = (op_sel == OP_SUB) || (op_sel == OP_CMP);
        is_cmp      = (op_sel == OP_CMP);
        is_ash      = (op_sel == OP_ASH);
    end

    xalu_opb_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opb (
        .use_imm (use_imm),
        .reg_val (opb_reg),
        .imm_val (imm),
        .opb     (opb)
    );

    xalu_addsub #(.XLEN(XLEN)) u_addsub (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_sub (is_sub_like),
        .do_cmp (is_cmp),
        .a      (opa),
        .b      (opb),
        .res    (as_res),
        .ovf    (as_ovf)
    );

    xalu_shift #(.XLEN(XLEN)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .arith (is_ash),
        .a     (opa),
        .cnt   (opb),
        .res   (sh_res)
    );

    // Steer the datapath outputs; only add and subtract pass overflow through.
    always_comb begin
        res_next = '0;
        ovf_next = 1'b0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                res_next = as_res;
                ovf_next = as_ovf;
            end
            OP_CMP:         res_next = as_res;
            OP_LSH, OP_ASH: res_next = sh_res;
            default: begin
                res_next = '0;
                ovf_next = 1'b0;
            end
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            logic [XLEN-1:0] res_q;
            logic            ovf_q;

            // Output stage: capture on each edge, clear on synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q <= '0;
                    ovf_q <= 1'b0;
                end else begin
                    res_q <= res_next;
                    ovf_q <= ovf_next;
                end
            end

            // Drive the ports from the output stage.
            always_comb begin
                result = res_q;
                ovf    = ovf_q;
            end

            // R8: no overflow one edge after a non-arithmetic code
            p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !(op_sel == OP_ADD || op_sel == OP_SUB) |=> !ovf);

            // R8: undefined codes give a zero result one edge later
            p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (op_sel > OP_ASH) |=> (result == '0));
        end else begin : g_comb
            // Drive the ports straight from the selection logic.
            always_comb begin
                result = res_next;
                ovf    = ovf_next;
            end
        end
    endgenerate
endmodule

// File: tb/tb_xalu_exec.sv
// Self-checking bench for xalu_exec in its default configuration.
// Expected values come from a 64-bit signed model written from the requirements.
module tb_xalu_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        use_imm = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb_reg = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xalu_exec dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_sel  (op_sel),
        .use_imm (use_imm),
        .opa     (opa),
        .opb_reg (opb_reg),
        .imm     (imm),
        .result  (result),
        .ovf     (ovf)
    );

    // Reference model: returns {ovf, result}.
    function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint t;
        logic [31:0] r = '0;
        logic o = 1'b0;
        bit inr;
        int n;
        case (op)
            3'd0, 3'd1, 3'd2: begin
                t = (op == 3'd0) ? sa + sb : sa - sb;
                inr = (t <= 64'sd2147483647) && (t >= -64'sd2147483648);
                if (op == 3'd2) r = inr ? t[31:0] : {t[63], t[30:0]};
                else begin r = t[31:0]; o = !inr; end
            end
            3'd3, 3'd4: begin
                if (sb >= 0) r = (sb >= 32) ? 32'd0 : (a << sb);
                else begin
                    n = (sb <= -32) ? 32 : int'(-sb);
                    if (op == 3'd3) r = (n >= 32) ? 32'd0 : (a >> n);
                    else r = (n >= 32) ? {32{a[31]}} : $unsigned($signed(a) >>> n);
                end
            end
            default: r = '0;
        endcase
        return {o, r};
    endfunction

    function automatic string rtag(input logic [2:0] op, input logic [31:0] b);
        longint sb = longint'($signed(b));
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: begin
                if (sb >= 32 || sb <= -32) return "R7";
                return (sb >= 0) ? "R5" : "R6";
            end
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got ovf=%0b res=%h expected ovf=%0b res=%h",
                     tag, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    // Drive on the falling edge, sample just after the next rising edge.
    task automatic run(input logic [2:0] op, input logic ui, input logic [31:0] a,
                       input logic [31:0] br, input logic [15:0] im, input string extra);
        logic [31:0] beff;
        @(negedge clk);
        op_sel = op; use_imm = ui; opa = a; opb_reg = br; imm = im;
        beff = ui ? {{16{im[15]}}, im} : br;
        @(posedge clk); #1;
        check({rtag(op, beff), extra}, {ovf, result}, model(op, a, beff));
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] edges [8];
        edges = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                  32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 32'h1234_5678};

        // R9: reset clears both outputs
        opa = 32'hFFFF_FFFF; opb_reg = 32'h7FFF_FFFF; op_sel = 3'd0;
        @(posedge clk); @(posedge clk); #1;
        check("R9 reset", {ovf, result}, 33'h0);
        @(negedge clk); rst_n = 1'b1;

        // R1: the immediate sign bit is extended
        run(3'd0, 1'b1, 32'h0, 32'h0, 16'h8000, " R1 imm");
        check("R1 sign-ext", {ovf, result}, {1'b0, 32'hFFFF_8000});
        run(3'd0, 1'b1, 32'h10, 32'hFFFF_FFFF, 16'h7FFF, " R1 imm");

        // R9: output holds until the edge, then updates
        @(negedge clk);
        op_sel = 3'd0; use_imm = 1'b0; opa = 32'd5; opb_reg = 32'd6;
        #1;
        check("R9 holds before edge", {ovf, result}, model(3'd0, 32'h10, 32'h7FFF));
        @(posedge clk); #1;
        check("R9 one-edge latency", {ovf, result}, {1'b0, 32'd11});

        // R2 R3 R4: boundary cross product; includes 0x80000000 - 1
        for (int op = 0; op < 3; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(3'(op), 1'b0, edges[i], edges[j], 16'h0, " boundary");

        // R5 R6 R7: every count from -40 to 40, register and immediate paths
        for (int op = 3; op < 5; op++)
            for (int i = 2; i < 8; i++)
                for (int c = -40; c <= 40; c++) begin
                    run(3'(op), 1'b0, edges[i], 32'(c), 16'h0, " shift-reg");
                    run(3'(op), 1'b1, edges[i], 32'h0, 16'(c), " shift-imm");
                end

        // R8: undefined codes give zero
        for (int op = 5; op < 8; op++)
            run(3'(op), 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, " undefined");

        // Random operand pairs over every code
        for (int k = 0; k < 3000; k++)
            run(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                $urandom, $urandom, 16'($urandom), " random");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule